// File: doc/BRIEF.md
# Dual Decimal Counter Adder Display

The block keeps two independent decimal counters, each spanning 0 to 99. It displays their values and their sum on six seven-segment digits. A counter moves by one step on each slow tick while its own push button is held down. A single direction switch decides whether the held counters count up or count down. The tick comes from a clock divider whose ratio is a parameter. At the default ratio, a 50 MHz clock gives two ticks per second.

The three binary values are turned into decimal digits by shift-and-add-three converters, and each digit drives one segment encoder. The sum can reach 198, which needs a hundreds digit. Instead of a seventh display digit, the block lights all ten discrete LEDs together whenever the sum is 100 or more, and turns all ten off otherwise.

Top module: `dual_bcd_adder_disp`

## Requirements
- R1: The reset input is asynchronous and active-low. While it is low, both counters and the divider are cleared, so every digit shows 0 and every LED is off.
- R2: A counter changes only on a tick clock edge on which its own synchronized button reads pressed. Buttons are active-low, and the two counters are independent.
- R3: The divider produces one tick every DIV clock cycles. After reset is released, the first tick edge is the DIV-th rising edge.
- R4: A button press reaches the counters through a two-flop synchronizer. A press or release driven just after edge k affects tick edges from edge k+3 onward.
- R5: With the direction input at 0, a held counter counts up, and from 99 it wraps to 0.
- R6: With the direction input at 1, a held counter counts down, and from 0 it wraps to 99. The switch applies to both counters.
- R7: The seg_a_hi and seg_a_lo outputs show the tens and units digits of counter A.
- R8: The seg_b_hi and seg_b_lo outputs show the tens and units digits of counter B.
- R9: The seg_s_hi and seg_s_lo outputs show the tens and units digits of A+B, taken modulo 100.
- R10: All ten bits of led_hund are 1 when A+B is 100 or more, and all are 0 otherwise.
- R11: Segment outputs are active-low, with bit 6 = g down to bit 0 = a. Digits 0 to 9 use these active-high gfedcba codes: 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_a_n | input | 1 | Counter A button, low = pressed |
| btn_b_n | input | 1 | Counter B button, low = pressed |
| dir_down | input | 1 | 0 = count up, 1 = count down |
| seg_a_hi | output | 7 | Counter A tens digit, active-low g..a |
| seg_a_lo | output | 7 | Counter A units digit |
| seg_b_hi | output | 7 | Counter B tens digit |
| seg_b_lo | output | 7 | Counter B units digit |
| seg_s_hi | output | 7 | Sum tens digit |
| seg_s_lo | output | 7 | Sum units digit |
| led_hund | output | 10 | Hundreds indicator, all on or all off |

## Verification
The hardest states to reach from the ports are the sums at the top of the range, 198, 197 and exactly 100. Reaching them takes long held runs on one counter while the other stays still. The stimulus therefore drives button windows whose length is an exact number of ticks. Each window starts right after a tick edge, with the divider ratio reduced to 4. It also walks through the down-wrap from 0 and the up-wrap from 99 on the way to those sums. One directed sequence places a single press against the first tick after reset, which pins down the synchronizer latency and the divider phase together.

// File: rtl/dcad_pkg.sv
`timescale 1ns/1ps
package dcad_pkg;
  typedef logic [6:0] seg_t;

  // active-low glyph, bit6=g .. bit0=a
  function automatic seg_t glyph(input logic [3:0] d);
    logic [6:0] on;
    case (d)
      4'd0: on = 7'h3F;
      4'd1: on = 7'h06;
      4'd2: on = 7'h5B;
      4'd3: on = 7'h4F;
      4'd4: on = 7'h66;
      4'd5: on = 7'h6D;
      4'd6: on = 7'h7D;
      4'd7: on = 7'h07;
      4'd8: on = 7'h7F;
      4'd9: on = 7'h6F;
      default: on = 7'h00;
    endcase
    return ~on;
  endfunction
endpackage

// File: rtl/dcad_sync.sv
`timescale 1ns/1ps
module dcad_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dcad_tick.sv
`timescale 1ns/1ps
module dcad_tick #(
  parameter int DIV = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: count stays in range and ticks are isolated
  a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  generate
    if (DIV > 1) begin : g_gap
      a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dcad_counter.sv
`timescale 1ns/1ps
module dcad_counter #(
  parameter int MAXV = 99,
  localparam int CW = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          press,
  input  logic          down,
  output logic [CW-1:0] value
);
  localparam logic [CW-1:0] TOP = CW'(MAXV);

  logic [CW-1:0] val_q, val_d;
  logic          step;

  assign step  = tick & press;
  assign value = val_q;

  always_comb begin
    val_d = val_q;
    if (step) begin
      if (down) val_d = (val_q == '0) ? TOP : val_q - 1'b1;
      else      val_d = (val_q == TOP) ? '0 : val_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    val_q <= TOP);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && press) |=> $stable(val_q));
  a_r5_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && press && !down && val_q != TOP) |=> val_q == CW'($past(val_q) + 1));
  a_r5_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && press && !down && val_q == TOP) |=> val_q == '0);
  a_r6_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && press && down && val_q == '0) |=> val_q == TOP);
endmodule

// File: rtl/dcad_bin2bcd.sv
`timescale 1ns/1ps
module dcad_bin2bcd #(
  parameter int W  = 8,
  parameter int ND = 3
) (
  input  logic [W-1:0]    bin,
  output logic [4*ND-1:0] bcd
);
  always_comb begin
    bcd = '0;
    for (int i = W - 1; i >= 0; i--) begin
      for (int d = 0; d < ND; d++) begin
        if (bcd[4*d +: 4] >= 4'd5) bcd[4*d +: 4] = bcd[4*d +: 4] + 4'd3;
      end
      bcd = {bcd[4*ND-2:0], bin[i]};
    end
  end
endmodule

// File: rtl/dual_bcd_adder_disp.sv
`timescale 1ns/1ps
module dual_bcd_adder_disp #(
  parameter int DIV   = 25_000_000,
  parameter int MAXV  = 99,
  parameter int NLED  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            btn_a_n,
  input  logic            btn_b_n,
  input  logic            dir_down,
  output logic [6:0]      seg_a_hi,
  output logic [6:0]      seg_a_lo,
  output logic [6:0]      seg_b_hi,
  output logic [6:0]      seg_b_lo,
  output logic [6:0]      seg_s_hi,
  output logic [6:0]      seg_s_lo,
  output logic [NLED-1:0] led_hund
);
  import dcad_pkg::*;

  localparam int CW = $clog2(MAXV + 1);
  localparam int SW = $clog2(2 * MAXV + 1);
  localparam int NDIG = 6;

  logic          tick;
  logic [2:0]    in_sync;
  logic [CW-1:0] cnt [2];
  logic [7:0]    cnt_bcd [2];
  logic [SW-1:0] sum;
  logic [11:0]   sum_bcd;
  logic [3:0]    dig [NDIG];
  seg_t          seg [NDIG];

  // idle buttons are high, direction up
  dcad_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({dir_down, btn_b_n, btn_a_n}),
    .q(in_sync)
  );

  dcad_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  generate
    for (genvar i = 0; i < 2; i++) begin : g_ctr
      dcad_counter #(.MAXV(MAXV)) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .press(~in_sync[i]), .down(in_sync[2]),
        .value(cnt[i])
      );
      dcad_bin2bcd #(.W(CW), .ND(2)) u_conv (.bin(cnt[i]), .bcd(cnt_bcd[i]));
      assign dig[2*i]     = cnt_bcd[i][7:4];
      assign dig[2*i + 1] = cnt_bcd[i][3:0];
    end
  endgenerate

  assign sum = SW'(cnt[0]) + SW'(cnt[1]);

  dcad_bin2bcd #(.W(SW), .ND(3)) u_sum_conv (.bin(sum), .bcd(sum_bcd));

  assign dig[4] = sum_bcd[7:4];
  assign dig[5] = sum_bcd[3:0];

  generate
    for (genvar k = 0; k < NDIG; k++) begin : g_seg
      assign seg[k] = glyph(dig[k]);
    end
  endgenerate

  assign led_hund = {NLED{sum_bcd[11:8] != 4'd0}};

  assign seg_a_hi = seg[0];
  assign seg_a_lo = seg[1];
  assign seg_b_hi = seg[2];
  assign seg_b_lo = seg[3];
  assign seg_s_hi = seg[4];
  assign seg_s_lo = seg[5];

  a_r10_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
    (led_hund == '0) || (led_hund == '1));
  a_r10_led_vs_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (led_hund != '0) == ((cnt[0] + cnt[1]) >= 100));
  a_r4_tick_only_change: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt[0]) && $stable(cnt[1])));
endmodule

// File: tb/dual_bcd_adder_disp_tb_top.sv
`timescale 1ns/1ps
module dual_bcd_adder_disp_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n, btn_a_n, btn_b_n, dir_down;
  logic [6:0] seg_a_hi, seg_a_lo, seg_b_hi, seg_b_lo, seg_s_hi, seg_s_lo;
  logic [9:0] led_hund;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dual_bcd_adder_disp #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
    .dir_down(dir_down), .seg_a_hi(seg_a_hi), .seg_a_lo(seg_a_lo),
    .seg_b_hi(seg_b_hi), .seg_b_lo(seg_b_lo), .seg_s_hi(seg_s_hi),
    .seg_s_lo(seg_s_lo), .led_hund(led_hund)
  );

  // R11 glyph codes, inverted for active-low
  function automatic logic [6:0] exp_seg(input int d);
    logic [6:0] g;
    case (d)
      0: g = 7'h3F; 1: g = 7'h06; 2: g = 7'h5B; 3: g = 7'h4F; 4: g = 7'h66;
      5: g = 7'h6D; 6: g = 7'h7D; 7: g = 7'h07; 8: g = 7'h7F; default: g = 7'h6F;
    endcase
    return ~g;
  endfunction

  task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(input int a, input int b);
    int s;
    s = a + b;
    chk("R7 R11 counter A digits", {seg_a_hi, seg_a_lo}, {exp_seg(a / 10), exp_seg(a % 10)});
    chk("R8 counter B digits", {seg_b_hi, seg_b_lo}, {exp_seg(b / 10), exp_seg(b % 10)});
    chk("R9 sum digits", {seg_s_hi, seg_s_lo}, {exp_seg((s % 100) / 10), exp_seg(s % 10)});
    chk("R10 hundreds LEDs", {4'd0, led_hund}, {4'd0, (s >= 100) ? 10'h3FF : 10'h000});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_state(0, 0); // R1
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // hold buttons for n ticks; starts and ends just after a tick edge
  task automatic run_vec(input logic a, input logic b, input logic dn, input int n);
    btn_a_n = ~a; btn_b_n = ~b; dir_down = dn;
    repeat (n * DIV) @(posedge clk);
    @(negedge clk);
    btn_a_n = 1'b1; btn_b_n = 1'b1;
    repeat (DIV) @(posedge clk);
    @(negedge clk);
  endtask

  // {press A, press B, down, ticks, exp A, exp B}
  localparam logic [24:0] VEC [12] = '{
    {1'b1, 1'b0, 1'b0, 8'd5,  7'd5,  7'd0 },  // R5 up, R2 only A
    {1'b0, 1'b1, 1'b0, 8'd7,  7'd5,  7'd7 },  // R2 only B
    {1'b1, 1'b1, 1'b0, 8'd3,  7'd8,  7'd10},
    {1'b1, 1'b1, 1'b1, 8'd10, 7'd98, 7'd0 },  // R6 down wrap on A
    {1'b0, 1'b1, 1'b1, 8'd1,  7'd98, 7'd99},  // R6 B 0 -> 99, sum 197
    {1'b1, 1'b0, 1'b0, 8'd2,  7'd0,  7'd99},  // R5 A 99 -> 0
    {1'b0, 1'b0, 1'b0, 8'd4,  7'd0,  7'd99},  // R2 no button
    {1'b1, 1'b0, 1'b0, 8'd99, 7'd99, 7'd99},  // sum 198
    {1'b1, 1'b1, 1'b0, 8'd1,  7'd0,  7'd0 },  // R5 both wrap
    {1'b1, 1'b1, 1'b0, 8'd50, 7'd50, 7'd50},  // sum exactly 100
    {1'b0, 1'b1, 1'b1, 8'd1,  7'd50, 7'd49},  // sum 99
    {1'b1, 1'b0, 1'b1, 8'd13, 7'd37, 7'd49}
  };

  initial begin
    rst_n = 1'b0; btn_a_n = 1'b1; btn_b_n = 1'b1; dir_down = 1'b0;
    #1;
    check_state(0, 0); // R1 power-up
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 R4: press right after release; first tick edge is edge DIV
    btn_a_n = 1'b0;
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    check_state(0, 0); // R3 no step before tick edge
    @(posedge clk);
    @(negedge clk);
    check_state(1, 0); // R4 press seen on first tick
    btn_a_n = 1'b1;
    repeat (DIV) @(posedge clk);
    @(negedge clk);
    check_state(1, 0); // R4 release seen before next tick

    // R1: asynchronous reset while a button is held
    btn_a_n = 1'b0;
    repeat (DIV) @(posedge clk);
    btn_a_n = 1'b1;
    do_reset();

    for (int i = 0; i < 12; i++) begin
      run_vec(VEC[i][24], VEC[i][23], VEC[i][22], int'(VEC[i][21:14]));
      check_state(int'(VEC[i][13:7]), int'(VEC[i][6:0]));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule